// File: doc/BRIEF.md
# Pause Control Frame Transmitter

This block assembles a full-duplex flow-control pause frame and streams it byte by byte to a transmit MAC. Software loads a small table of 48-bit entries through a write port. Entry 0 holds the destination address, which is normally the reserved multicast address for control frames. Entry 1 holds the source address, which is normally the local station address. Entry 20 holds the control type, the pause opcode and a 16-bit pause-time operand. Software then sets a send-pause command bit. The block waits until any normal frame on the shared transmit path has finished. It then emits the frame, appending zero bytes until the frame is 60 bytes long, which leaves room for the 4-byte check sequence added downstream.

The stream uses a valid/ready handshake and marks the final byte with a last flag. When the last byte is accepted, three things happen: the command bit clears itself, a completion status word is stored, and an interrupt is raised if bit 10 of the interrupt enable register is set. The interrupt stays raised until it is acknowledged. The preamble, check sequence generation and the PHY side are handled elsewhere.

Top module: `pause_frame_tx`

## Requirements
- R1: After reset, tx_valid, tx_last, irq and sp_pending are 0 and ctl_status is 0x0000.
- R2: Frame bytes 0 to 5 are table entry 0, most significant byte first (byte 0 is bits 47:40).
- R3: Frame bytes 6 to 11 are table entry 1, most significant byte first.
- R4: Frame bytes 12 to 17 are table entry 20, most significant byte first. In that entry, bits 47:32 are the type, bits 31:16 are the opcode and bits 15:0 are the pause-time operand. Every operand value from 0x0000 to 0xFFFF is sent unchanged.
- R5: Frame bytes 18 to 59 are zero. The frame is exactly 60 accepted bytes, and tx_last is 1 only on byte 59.
- R6: A one-cycle pulse on sp_set makes sp_pending 1 after the next clock edge. If norm_busy is low, tx_valid rises at the edge after that.
- R7: While norm_busy is high, a pending pause frame does not start. It starts at the edge that follows the first cycle in which norm_busy is low.
- R8: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_data and tx_last hold their values into the next cycle.
- R9: sp_pending clears at the edge on which the last byte is accepted, and no second frame follows.
- R10: At that same edge, ctl_status becomes 0x3C01. The upper byte is the frame length of 60 and bit 0 marks completion.
- R11: At that edge, irq becomes 1 only if bit 10 of the interrupt enable register (written with ien_wr/ien_wdata) is 1. Otherwise irq stays 0. A pulse on irq_ack clears irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 5 | Table entry index |
| tbl_wdata | input | 48 | Table entry write data |
| sp_set | input | 1 | Pulse that sets the send-pause command bit |
| sp_pending | output | 1 | Send-pause command bit |
| norm_busy | input | 1 | A normal frame is using the transmit path |
| ien_wr | input | 1 | Interrupt enable register write strobe |
| ien_wdata | input | 16 | Interrupt enable write data; bit 10 enables completion interrupt |
| irq_ack | input | 1 | Clears the completion interrupt |
| irq | output | 1 | Completion interrupt |
| ctl_status | output | 16 | Control-frame transmit status |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The hardest case to reach is a start that is held off by a busy normal frame while the downstream side is also applying irregular backpressure, including on the very last byte. In that case completion, the self-clearing command bit, the status write and the masked interrupt all depend on which edge accepts byte 59. The stimulus sets the command while norm_busy is high and keeps it high for several cycles. It then drives tx_ready from a pseudo-random sequence, and a cycle-accurate behavioural model predicts every output on every clock. Three different pause operands are used, including 0x0000 and 0xFFFF, with the interrupt enabled for some frames and masked for others.

// File: rtl/pft_pkg.sv
package pft_pkg;

    localparam int ENTRY_W_DEF     = 48;
    localparam int FRAME_BYTES_DEF = 60;
    localparam int TBL_DEPTH_DEF   = 32;
    localparam int STAT_W_DEF      = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/pft_table.sv
module pft_table #(
    parameter int DEPTH   = 32,
    parameter int W       = 48,
    parameter int DST_IDX = 0,
    parameter int SRC_IDX = 1,
    parameter int CTL_IDX = 20,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  dst_word,
    output logic [W-1:0]  src_word,
    output logic [W-1:0]  ctl_word
);

    logic [W-1:0] rows [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && addr == AW'(i)) begin
                ent_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign rows[i] = ent_q;
    end

    assign dst_word = rows[DST_IDX];
    assign src_word = rows[SRC_IDX];
    assign ctl_word = rows[CTL_IDX];

endmodule

// File: rtl/pft_seq.sv
module pft_seq
    import pft_pkg::*;
#(
    parameter int FRAME_BYTES = 60,
    parameter int ENTRY_W     = 48,
    localparam int CNT_W      = $clog2(FRAME_BYTES),
    localparam int BPE        = ENTRY_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic               norm_busy,
    input  logic [ENTRY_W-1:0] dst_word,
    input  logic [ENTRY_W-1:0] src_word,
    input  logic [ENTRY_W-1:0] ctl_word,
    input  logic               tx_ready,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic               tx_last,
    output logic               done
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BYTES - 1);

    typedef struct packed {
        tx_state_e        st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic fire;

    function automatic logic [7:0] pick(input logic [ENTRY_W-1:0] w, input int k);
        logic [ENTRY_W-1:0] s;
        s = w >> (8 * (BPE - 1 - k));
        return s[7:0];
    endfunction

    always_comb begin
        seq_d = seq_q;
        fire  = (seq_q.st == ST_SEND) && tx_ready;
        done  = fire && (seq_q.cnt == LAST_CNT);
        case (seq_q.st)
            ST_IDLE: begin
                if (start_req && !norm_busy) begin
                    seq_d.st  = ST_SEND;
                    seq_d.cnt = '0;
                end
            end
            ST_SEND: begin
                if (fire) begin
                    if (seq_q.cnt == LAST_CNT) begin
                        seq_d.st  = ST_IDLE;
                        seq_d.cnt = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            default: seq_d = '{st: ST_IDLE, cnt: '0};
        endcase
    end

    always_comb begin
        int idx;
        idx      = int'(seq_q.cnt);
        tx_valid = (seq_q.st == ST_SEND);
        tx_last  = tx_valid && (seq_q.cnt == LAST_CNT);
        if (!tx_valid)           tx_data = '0;
        else if (idx < BPE)      tx_data = pick(dst_word, idx);
        else if (idx < 2 * BPE)  tx_data = pick(src_word, idx - BPE);
        else if (idx < 3 * BPE)  tx_data = pick(ctl_word, idx - 2 * BPE);
        else                     tx_data = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, cnt: '0};
        else        seq_q <= seq_d;
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R5
    last_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R7
    start_idle_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(!norm_busy && start_req));

endmodule

// File: rtl/pft_csr.sv
module pft_csr #(
    parameter int FRAME_BYTES = 60,
    parameter int STAT_W      = 16,
    parameter int IEN_W       = 16,
    parameter int IRQ_BIT     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sp_set,
    input  logic              ien_wr,
    input  logic [IEN_W-1:0]  ien_wdata,
    input  logic              irq_ack,
    input  logic              done,
    output logic              sp_pending,
    output logic              irq,
    output logic [STAT_W-1:0] ctl_status
);

    localparam logic [STAT_W-1:0] STAT_DONE = STAT_W'((FRAME_BYTES << 8) | 1);

    typedef struct packed {
        logic              sp;
        logic [IEN_W-1:0]  ien;
        logic              irq;
        logic [STAT_W-1:0] stat;
    } csr_t;

    csr_t csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (sp_set)    csr_d.sp = 1'b1;
        else if (done) csr_d.sp = 1'b0;
        if (ien_wr)    csr_d.ien = ien_wdata;
        if (done && csr_q.ien[IRQ_BIT]) csr_d.irq = 1'b1;
        else if (irq_ack)               csr_d.irq = 1'b0;
        if (done)      csr_d.stat = STAT_DONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    assign sp_pending = csr_q.sp;
    assign irq        = csr_q.irq;
    assign ctl_status = csr_q.stat;

    // R9
    sp_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sp_set) |=> !sp_pending);

    // R10
    status_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ctl_status == STAT_DONE));

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done && csr_q.ien[IRQ_BIT]));

endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx
    import pft_pkg::*;
#(
    parameter int TBL_DEPTH   = TBL_DEPTH_DEF,
    parameter int ENTRY_W     = ENTRY_W_DEF,
    parameter int FRAME_BYTES = FRAME_BYTES_DEF,
    parameter int STAT_W      = STAT_W_DEF,
    parameter int IEN_W       = 16,
    parameter int IRQ_BIT     = 10,
    parameter int DST_IDX     = 0,
    parameter int SRC_IDX     = 1,
    parameter int CTL_IDX     = 20,
    localparam int TBL_AW     = $clog2(TBL_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [TBL_AW-1:0]  tbl_addr,
    input  logic [ENTRY_W-1:0] tbl_wdata,
    input  logic               sp_set,
    output logic               sp_pending,
    input  logic               norm_busy,
    input  logic               ien_wr,
    input  logic [IEN_W-1:0]   ien_wdata,
    input  logic               irq_ack,
    output logic               irq,
    output logic [STAT_W-1:0]  ctl_status,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_data,
    output logic               tx_last
);

    logic [ENTRY_W-1:0] dst_word, src_word, ctl_word;
    logic               done;

    pft_table #(
        .DEPTH(TBL_DEPTH), .W(ENTRY_W),
        .DST_IDX(DST_IDX), .SRC_IDX(SRC_IDX), .CTL_IDX(CTL_IDX)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .addr(tbl_addr), .wdata(tbl_wdata),
        .dst_word(dst_word), .src_word(src_word), .ctl_word(ctl_word)
    );

    pft_seq #(
        .FRAME_BYTES(FRAME_BYTES), .ENTRY_W(ENTRY_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(sp_pending), .norm_busy(norm_busy),
        .dst_word(dst_word), .src_word(src_word), .ctl_word(ctl_word),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .done(done)
    );

    pft_csr #(
        .FRAME_BYTES(FRAME_BYTES), .STAT_W(STAT_W), .IEN_W(IEN_W), .IRQ_BIT(IRQ_BIT)
    ) u_csr (
        .clk(clk), .rst_n(rst_n), .sp_set(sp_set), .ien_wr(ien_wr),
        .ien_wdata(ien_wdata), .irq_ack(irq_ack), .done(done),
        .sp_pending(sp_pending), .irq(irq), .ctl_status(ctl_status)
    );

    // R6
    valid_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> sp_pending);

endmodule

// File: tb/pause_frame_tx_test.sv
module pause_frame_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_addr = '0;
    logic [47:0] tbl_wdata = '0;
    logic        sp_set = 1'b0;
    logic        sp_pending;
    logic        norm_busy = 1'b0;
    logic        ien_wr = 1'b0;
    logic [15:0] ien_wdata = '0;
    logic        irq_ack = 1'b0;
    logic        irq;
    logic [15:0] ctl_status;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_last;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [47:0] m_tab [32];
    bit          m_sp, m_send, m_irq;
    int          m_idx;
    logic [15:0] m_ien, m_status;
    bit [7:0]    m_bytes [$];
    int          accepted;

    always #5 clk = ~clk;

    pause_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .sp_set(sp_set), .sp_pending(sp_pending),
        .norm_busy(norm_busy), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
        .irq_ack(irq_ack), .irq(irq), .ctl_status(ctl_status),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string region(input int i);
        if (i < 6)  return "R2";
        if (i < 12) return "R3";
        if (i < 18) return "R4";
        return "R5";
    endfunction

    function automatic void build_frame();
        logic [47:0] w;
        m_bytes.delete();
        for (int e = 0; e < 3; e++) begin
            w = (e == 0) ? m_tab[0] : (e == 1) ? m_tab[1] : m_tab[20];
            for (int b = 0; b < 6; b++) begin
                m_bytes.push_back(w[47:40]);
                w = w << 8;
            end
        end
        while (m_bytes.size() < 60) m_bytes.push_back(8'h00);
    endfunction

    // compare, then advance model across one rising edge; called just after a falling edge
    task automatic tick();
        bit exp_last, done;
        exp_last = m_send && (m_idx == 59);
        check(tx_valid == m_send, "R6 R7", "tx_valid", tx_valid, m_send);
        check(tx_last == exp_last, "R5", "tx_last", tx_last, exp_last);
        if (m_send)
            check(tx_data == m_bytes[m_idx], region(m_idx), "tx_data", tx_data, m_bytes[m_idx]);
        check(sp_pending == m_sp, "R9", "sp_pending", sp_pending, m_sp);
        check(irq == m_irq, "R11", "irq", irq, m_irq);
        check(ctl_status == m_status, "R10", "ctl_status", ctl_status, m_status);

        done = m_send && tx_ready && (m_idx == 59);
        @(posedge clk);
        if (tbl_we) m_tab[tbl_addr] = tbl_wdata;
        if (m_send && tx_ready) begin
            accepted++;
            m_idx++;
        end
        if (done) begin
            m_send   = 0;
            m_idx    = 0;
            m_status = 16'h3C01;
        end else if (!m_send && m_sp && !norm_busy) begin
            m_send = 1;
            m_idx  = 0;
            build_frame();
        end
        if (done && m_ien[10]) m_irq = 1;
        else if (irq_ack)      m_irq = 0;
        if (sp_set)    m_sp = 1;
        else if (done) m_sp = 0;
        if (ien_wr) m_ien = ien_wdata;
        @(negedge clk);
    endtask

    task automatic wr_tab(input int a, input logic [47:0] v);
        tbl_we = 1; tbl_addr = 5'(a); tbl_wdata = v;
        tick();
        tbl_we = 0;
    endtask

    task automatic wr_ien(input logic [15:0] v);
        ien_wr = 1; ien_wdata = v;
        tick();
        ien_wr = 0;
    endtask

    logic [7:0] lfsr = 8'hA5;
    task automatic run_frame(input int mode);
        int guard = 0;
        accepted = 0;
        while ((m_sp || m_send) && guard < 2000) begin
            if (mode == 0)      tx_ready = 1;
            else if (mode == 1) tx_ready = (guard % 2 == 1);
            else begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                tx_ready = lfsr[0] | lfsr[2];
            end
            tick();
            guard++;
        end
        tx_ready = 1;
        check(accepted == 60, "R5", "accepted byte count", accepted, 60);
        repeat (3) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_tab[i] = '0;
        m_sp = 0; m_send = 0; m_irq = 0; m_idx = 0; m_ien = '0; m_status = '0;
        build_frame();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!tx_valid && !tx_last, "R1", "tx_valid/tx_last", {tx_valid, tx_last}, 0);
        check(!irq && !sp_pending, "R1", "irq/sp_pending", {irq, sp_pending}, 0);
        check(ctl_status == 16'h0000, "R1", "ctl_status", ctl_status, 0);

        // frame 1: interrupt enabled, full-rate output
        wr_tab(0, 48'h0180_C200_0001);
        wr_tab(1, 48'h0011_2233_4455);
        wr_tab(20, 48'h8808_0001_0ABC);
        wr_tab(5, 48'hDEAD_BEEF_CAFE);
        wr_ien(16'h0400);
        sp_set = 1; tick(); sp_set = 0;   // R6: pending next, valid the edge after
        run_frame(0);
        check(irq == 1'b1, "R11", "irq after enabled frame", irq, 1);
        irq_ack = 1; tick(); irq_ack = 0;
        check(irq == 1'b0, "R11", "irq after ack", irq, 0);

        // frame 2: masked interrupt, held off by normal frame, random backpressure
        wr_ien(16'hFBFF);
        wr_tab(20, 48'h8808_0001_FFFF);
        norm_busy = 1;
        sp_set = 1; tick(); sp_set = 0;
        repeat (8) tick();                // R7: must not start
        norm_busy = 0;
        run_frame(2);
        check(irq == 1'b0, "R11", "irq with bit 10 clear", irq, 0);

        // frame 3: zero operand, alternating ready, interrupt re-enabled
        wr_tab(20, 48'h8808_0001_0000);
        wr_tab(0, 48'hFFFF_FFFF_FFFF);
        wr_ien(16'h0400);
        sp_set = 1; tick(); sp_set = 0;
        run_frame(1);
        check(irq == 1'b1, "R11", "irq after third frame", irq, 1);
        check(ctl_status == 16'h3C01, "R10", "status after third frame", ctl_status, 16'h3C01);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule